// File: doc/BRIEF.md
# Core Clock Rate Scaler

This block thins a parent clock into a clock-enable stream for a processor core. Time is cut into frames of 32 parent cycles. In each frame the enable is high on 32 minus the active ratio value cycles, so the effective rate is parent × (32 − ratio) / 32. A ratio of 0 keeps the enable high on every cycle. A ratio of 31 gives one enable per frame. The enables are spread across the frame by a phase accumulator rather than bunched together.

Software changes the rate in two steps, through a small synchronous register port. First it writes a staged ratio. Then it sets a commit bit. The commit bit reads back, and shows on `busy`, until the hardware copies the staged ratio into the active ratio. That copy happens only at the next frame boundary, so every frame runs on a single ratio. While the commit is pending, the staged ratio is locked.

Top module: `clk_rate_scaler`

## Requirements
- R1: After reset, the staged and active ratios are 0 and `busy` is 0. Every readable register returns 0. `clk_en` is high on every cycle.
- R2: Each 32-cycle frame carries exactly 32 − A cycles with `clk_en` high, where A is the active ratio. A = 0 gives an enable on all 32 cycles and A = 31 gives exactly one.
- R3: Let k = 32 − A and number the cycles of a frame i = 0..31. `clk_en` is high in cycle i exactly when floor((i+1)·k/32) > floor(i·k/32).
- R4: The ratio register sits at offset 1 and holds the staged ratio in bits 12:8. A write to it stores only bits 12:8 of the write data. A read returns the staged ratio in bits 12:8 with all other bits 0.
- R5: The command register sits at offset 0. Writing it with bit 31 = 1 while idle makes `busy` 1 from the next cycle. Writing it with bit 31 = 0 leaves `busy` unchanged.
- R6: A pending commit loads the staged ratio into the active ratio at the end of the current frame, and `busy` clears at that same edge. The new ratio governs the frame that starts on the next cycle. `busy` stays high for at most 32 cycles.
- R7: While `busy` is 1, writes to the ratio register and further command writes have no effect.
- R8: Read data appears on `reg_rdata` the cycle after `reg_rd`. A read of the command register returns `busy` in bit 31 with all other bits 0. Offsets 2 and 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| clk_en | output | 1 | Core clock-enable pulse stream |
| busy | output | 1 | Commit pending |

## Verification
Some properties are checked on every cycle:
- the active ratio changes only at a frame boundary;
- `busy` falls only at a frame boundary;
- `busy` rises after an idle commit write and stays low after a write of 0;
- the staged ratio holds while a commit is pending;
- a zero active ratio forces `clk_en` high;
- unmapped reads return 0.

Only the bench scenarios can show the pulse count and exact pulse placement for each of the 32 ratios, the commit latency, and the field-only storage and readback of register writes.

// File: rtl/crs_pkg.sv
package crs_pkg;
  localparam int unsigned RATIO_W   = 5;
  localparam int unsigned RATIO_LSB = 8;
  localparam int unsigned KICK_BIT  = 31;
  localparam int unsigned OFF_CMD   = 0;
  localparam int unsigned OFF_RATIO = 1;
endpackage

// File: rtl/crs_pulse_gen.sv
module crs_pulse_gen #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] active,
  output logic         clk_en,
  output logic         frame_last
);
  localparam logic [W:0] FULL = (W+1)'(1) << W;

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] acc_q, acc_d;
  logic [W:0]   inc;
  logic [W:0]   sum;

  always_comb begin
    inc        = FULL - {1'b0, active};
    sum        = {1'b0, acc_q} + inc;
    clk_en     = sum[W];
    acc_d      = sum[W-1:0];
    cnt_d      = cnt_q + 1'b1;
    frame_last = &cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/crs_regfile.sv
module crs_regfile #(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned RATIO_W   = 5,
  parameter int unsigned RATIO_LSB = 8,
  parameter int unsigned KICK_BIT  = 31,
  parameter int unsigned OFF_CMD   = 0,
  parameter int unsigned OFF_RATIO = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               frame_last,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [RATIO_W-1:0] staged,
  output logic [RATIO_W-1:0] active,
  output logic               kick
);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_RATIO = ADDR_W'(OFF_RATIO);

  logic [RATIO_W-1:0] staged_d, active_d;
  logic               kick_d;
  logic [DATA_W-1:0]  rdata_d;
  logic               wr_cmd, wr_ratio, commit;
  logic               staged_en, active_en, rdata_en;

  always_comb begin
    wr_cmd    = reg_wr && (reg_addr == A_CMD);
    wr_ratio  = reg_wr && (reg_addr == A_RATIO);
    commit    = kick && frame_last;

    staged_en = wr_ratio && !kick;
    staged_d  = reg_wdata[RATIO_LSB +: RATIO_W];

    active_en = commit;
    active_d  = staged;

    kick_d = kick;
    if (commit)
      kick_d = 1'b0;
    else if (wr_cmd && reg_wdata[KICK_BIT])
      kick_d = 1'b1;

    rdata_en = reg_rd;
    rdata_d  = '0;
    if (reg_addr == A_CMD)
      rdata_d[KICK_BIT] = kick;
    else if (reg_addr == A_RATIO)
      rdata_d[RATIO_LSB +: RATIO_W] = staged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged    <= '0;
      active    <= '0;
      kick      <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (staged_en) staged    <= staged_d;
      if (active_en) active    <= active_d;
      kick <= kick_d;
      if (rdata_en)  reg_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/clk_rate_scaler.sv
module clk_rate_scaler #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              clk_en,
  output logic              busy
);
  localparam int unsigned RW = crs_pkg::RATIO_W;

  logic [1:0]    rst_sync;
  logic          rst_int_n;
  logic [RW-1:0] staged, active;
  logic          frame_last;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  crs_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATIO_W(RW),
    .RATIO_LSB(crs_pkg::RATIO_LSB), .KICK_BIT(crs_pkg::KICK_BIT),
    .OFF_CMD(crs_pkg::OFF_CMD), .OFF_RATIO(crs_pkg::OFF_RATIO)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .frame_last(frame_last), .reg_rdata(reg_rdata),
    .staged(staged), .active(active), .kick(busy)
  );

  crs_pulse_gen #(.W(RW)) u_pulse (
    .clk(clk), .rst_n(rst_int_n), .active(active),
    .clk_en(clk_en), .frame_last(frame_last)
  );
endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              clk_en,
  input logic              busy,
  input logic              frame_last,
  input logic [RW-1:0]     active,
  input logic [RW-1:0]     staged
);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(crs_pkg::OFF_CMD);
  localparam logic [ADDR_W-1:0] A_RAT = ADDR_W'(crs_pkg::OFF_RATIO);

  a_r2_zero_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |-> clk_en);

  a_r5_kick_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_wr && reg_addr == A_CMD && reg_wdata[crs_pkg::KICK_BIT]) |=> busy);

  a_r5_zero_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_wr && reg_addr == A_CMD && !reg_wdata[crs_pkg::KICK_BIT]) |=> !busy);

  a_r6_clear_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(frame_last));

  a_r6_active_frame_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_last) |-> $stable(active));

  a_r7_staged_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(staged));

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr != A_CMD && reg_addr != A_RAT) |=> (reg_rdata == '0));
endmodule

bind clk_rate_scaler crs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .clk_en(clk_en), .busy(busy), .frame_last(frame_last),
  .active(active), .staged(staged)
);

// File: tb/sim_clk_rate_scaler.sv
module sim_clk_rate_scaler;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        clk_en, busy;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_rate_scaler u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .clk_en(clk_en), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic bit exp_en(input int i, input int k);
    return (((i + 1) * k) / 32) != ((i * k) / 32);
  endfunction

  // Caller is at a negedge in cycle 0 of a frame running ratio r.
  task automatic check_frame(input int r);
    int k = 32 - r;
    int cnt = 0;
    int bad = 0;
    for (int i = 0; i < 32; i++) begin
      if (clk_en) cnt++;
      if (clk_en !== exp_en(i, k)) bad++;
      @(negedge clk);
    end
    chk("R2 pulse count", cnt, k);
    chk("R3 pulse placement mismatches", bad, 0);
  endtask

  task automatic wait_commit(input int r);
    int n = 0;
    while (busy === 1'b1 && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk("R6 commit latency within frame", (n <= 32) ? 1 : 0, 1);
    check_frame(r);
  endtask

  task automatic set_ratio(input int r);
    logic [31:0] d;
    wr(2'd1, 32'(r) << 8);
    rd(2'd1, d);
    chk("R4 ratio readback", d, 32'(r) << 8);
    wr(2'd0, 32'h8000_0000);
    chk("R5 busy after kick", {31'b0, busy}, 1);
    wait_commit(r);
  endtask

  initial begin
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 busy after reset", {31'b0, busy}, 0);
    rd(2'd0, d); chk("R1 command reg after reset", d, 0);
    rd(2'd1, d); chk("R1 ratio reg after reset", d, 0);
    begin
      int hi = 0;
      for (int i = 0; i < 32; i++) begin
        if (clk_en) hi++;
        @(negedge clk);
      end
      chk("R1 full rate after reset", hi, 32);
    end

    // R8 unmapped offsets
    rd(2'd2, d); chk("R8 offset 2 reads zero", d, 0);
    rd(2'd3, d); chk("R8 offset 3 reads zero", d, 0);

    // R4 only field bits stored
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R4 field-only store", d, 32'h0000_1F00);

    // R5 zero write when idle
    wr(2'd0, 32'h7FFF_FFFF);
    chk("R5 zero kick idle no effect", {31'b0, busy}, 0);

    // R2 R3 R6 sweep over every ratio
    for (int r = 0; r < 32; r++) set_ratio(r);
    set_ratio(0);
    set_ratio(31);
    set_ratio(5);
    set_ratio(27);

    // R7 lock while busy; we are at cycle 0 of a frame here
    set_ratio(3);
    wr(2'd0, 32'h8000_0000);
    wr(2'd1, 32'h0000_1400);
    rd(2'd1, d); chk("R7 ratio write ignored while busy", d, 32'h0000_0300);
    wr(2'd0, 32'h0000_0000);
    chk("R7 zero kick while busy no effect", {31'b0, busy}, 1);
    rd(2'd0, d); chk("R8 command reads busy bit", d, 32'h8000_0000);
    wait_commit(3);
    rd(2'd0, d); chk("R8 command reads idle", d, 0);
    rd(2'd1, d); chk("R7 staged kept after commit", d, 32'h0000_0300);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule